// File: doc/BRIEF.md
# Segmented Virtual Address Translator with Fault Capture

This block turns a 32-bit virtual address into a physical address by looking at the top three address bits, which split the space into eight fixed 512 MB windows. Some windows are direct-mapped: a constant offset is removed and the result is given read and write permission. The other windows are handed to an external TLB. The TLB reports its lookup result in the same cycle, and the block turns that result into a physical address, a permission pair, or an exception. The block also puts out the address space identifier that the TLB should match against.

Each request produces one registered response in the next cycle. A faulting response carries an exception code and a refill indicator. The same clock edge loads three capture registers: the faulting virtual address, a context word, and an entry-high word. The context and entry-high words each keep a field of their previous value and take a slice of the faulting address for the rest. Software can read these registers back and can write them through a small register port. This is how the preserved fields get their values.

Top module: `xlate_mmu_front`

## Requirements
- R1: A request in user mode (`req_user`=1) whose address has bit 31 set faults with exception code 4 on a read or 5 on a write. The refill indicator is 0 and no TLB lookup is requested.
- R2: With `req_errlvl`=0, an address below 0x80000000 requests a TLB lookup (`tlb_req`=1 in the request cycle), and the response is built from the TLB result.
- R3: With `req_errlvl`=1, an address below 0x80000000 maps to the same physical address with read and write permission, and no TLB lookup is requested.
- R4: In kernel mode, an address in 0x80000000..0x9FFFFFFF maps to the address minus 0x80000000, with read and write permission and no TLB lookup.
- R5: In kernel mode, an address in 0xA0000000..0xBFFFFFFF maps to the address minus 0xA0000000, with read and write permission and no TLB lookup.
- R6: In kernel mode, an address at or above 0xC0000000 requests a TLB lookup, whatever the value of `req_errlvl`.
- R7: For a TLB hit on a valid entry, the physical address is `tlb_paddr`. Read permission is always granted, and write permission equals `tlb_dirty`. A write to an entry whose dirty bit is clear faults with code 1 and refill 0.
- R8: A TLB miss (`tlb_hit`=0) faults with code 2 on a read or 3 on a write, with refill 1. A hit on an entry that is not valid gives the same codes with refill 0.
- R9: A faulting response has physical address 0 and both permissions 0. The bad-address register (select 0) loads the full faulting address.
- R10: On a fault, the context register (select 1) keeps its bits 31:23 and replaces its other bits with (address >> 9) & 0x007FFFF0.
- R11: On a fault, the entry-high register (select 2) keeps its bits 7:0 and replaces its other bits with address & 0xFFFFE000. `tlb_asid` always shows entry-high bits 7:0.
- R12: The capture registers change only on a fault response or a register write. A write takes effect on the next edge. If a write and a fault fall on the same edge, the fault wins. Select 3 reads 0.
- R13: A response (`rsp_valid`=1) appears exactly one cycle after a request. After reset, `rsp_valid` is 0 and all capture registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | User-mode access |
| req_errlvl | input | 1 | Error-level flag; makes the low half of the address space unmapped |
| tlb_req | output | 1 | TLB lookup requested for this cycle's address |
| tlb_asid | output | 8 | Address space identifier for the lookup |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_valid | input | 1 | Valid bit of the matching page |
| tlb_dirty | input | 1 | Dirty (writable) bit of the matching page |
| tlb_paddr | input | 32 | Physical address from the TLB |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_fault | output | 1 | Translation fault |
| rsp_exc | output | 5 | Exception code (0 when no fault) |
| rsp_refill | output | 1 | Fault came from a TLB miss |
| reg_wr_en | input | 1 | Capture register write strobe |
| reg_wr_sel | input | 2 | Capture register selected for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Capture register selected for read-back |
| reg_rd_data | output | 32 | Read-back data |

## Verification
The only result that is due in the same cycle is `tlb_req`. It is combinational, so the bench samples it one time unit after it drives a request on the falling edge. The response fields and the capture registers change on the rising edge that follows. The bench therefore reads them on the next falling edge, while the response is still held and before a new request can overwrite it. A register write is read back only after the edge that follows the write strobe. This keeps each check tied to the one edge on which its value is defined.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W      = 32;
  localparam int ASID_W    = 8;
  localparam int WIN_W     = 3;
  localparam int N_CAP     = 3;
  localparam int CAP_SEL_W = $clog2(N_CAP + 1);

  localparam logic [VA_W-1:0] WIN4_BASE = 32'h8000_0000;
  localparam logic [VA_W-1:0] WIN5_BASE = 32'hA000_0000;
  localparam logic [VA_W-1:0] CTX_KEEP  = 32'hFF80_0000;
  localparam logic [VA_W-1:0] CTX_SLICE = 32'h007F_FFF0;
  localparam logic [VA_W-1:0] EHI_KEEP  = 32'h0000_00FF;
  localparam logic [VA_W-1:0] EHI_SLICE = 32'hFFFF_E000;

  typedef enum logic [1:0] {
    SEG_DIRECT  = 2'd0,
    SEG_TLB     = 2'd1,
    SEG_BADADDR = 2'd2
  } seg_kind_e;

  typedef enum logic [4:0] {
    EXC_NONE = 5'd0,
    EXC_MOD  = 5'd1,
    EXC_TLBL = 5'd2,
    EXC_TLBS = 5'd3,
    EXC_ADEL = 5'd4,
    EXC_ADES = 5'd5
  } exc_e;

  typedef struct packed {
    logic            fault;
    exc_e            exc;
    logic            refill;
    logic [VA_W-1:0] paddr;
    logic            rd_ok;
    logic            wr_ok;
  } xlate_rsp_t;
endpackage

// File: rtl/xlate_seg_decode.sv
module xlate_seg_decode
  import xlate_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic            user,
  input  logic            errlvl,
  output seg_kind_e       kind,
  output logic [VA_W-1:0] direct_paddr
);
  logic [WIN_W-1:0] window;
  assign window = vaddr[VA_W-1 -: WIN_W];

  always_comb begin
    kind         = SEG_TLB;
    direct_paddr = vaddr;
    if (user && vaddr[VA_W-1]) begin
      kind = SEG_BADADDR;
    end else begin
      unique case (window)
        3'd0, 3'd1, 3'd2, 3'd3: kind = errlvl ? SEG_DIRECT : SEG_TLB;
        3'd4: begin
          kind         = SEG_DIRECT;
          direct_paddr = vaddr - WIN4_BASE;
        end
        3'd5: begin
          kind         = SEG_DIRECT;
          direct_paddr = vaddr - WIN5_BASE;
        end
        default: kind = SEG_TLB;
      endcase
    end
  end
endmodule

// File: rtl/xlate_fault_classify.sv
module xlate_fault_classify
  import xlate_pkg::*;
(
  input  seg_kind_e       kind,
  input  logic [VA_W-1:0] direct_paddr,
  input  logic            write,
  input  logic            tlb_hit,
  input  logic            tlb_valid,
  input  logic            tlb_dirty,
  input  logic [VA_W-1:0] tlb_paddr,
  output xlate_rsp_t      rsp
);
  always_comb begin
    rsp        = '0;
    rsp.exc    = EXC_NONE;
    unique case (kind)
      SEG_DIRECT: begin
        rsp.paddr = direct_paddr;
        rsp.rd_ok = 1'b1;
        rsp.wr_ok = 1'b1;
      end
      SEG_BADADDR: begin
        rsp.fault = 1'b1;
        rsp.exc   = write ? EXC_ADES : EXC_ADEL;
      end
      default: begin
        if (!tlb_hit) begin
          rsp.fault  = 1'b1;
          rsp.refill = 1'b1;
          rsp.exc    = write ? EXC_TLBS : EXC_TLBL;
        end else if (!tlb_valid) begin
          rsp.fault = 1'b1;
          rsp.exc   = write ? EXC_TLBS : EXC_TLBL;
        end else if (write && !tlb_dirty) begin
          rsp.fault = 1'b1;
          rsp.exc   = EXC_MOD;
        end else begin
          rsp.paddr = tlb_paddr;
          rsp.rd_ok = 1'b1;
          rsp.wr_ok = tlb_dirty;
        end
      end
    endcase
  end
endmodule

// File: rtl/xlate_capture_regs.sv
module xlate_capture_regs
  import xlate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_en,
  input  logic [VA_W-1:0]      cap_vaddr,
  input  logic                 wr_en,
  input  logic [CAP_SEL_W-1:0] wr_sel,
  input  logic [VA_W-1:0]      wr_data,
  input  logic [CAP_SEL_W-1:0] rd_sel,
  output logic [VA_W-1:0]      rd_data,
  output logic [ASID_W-1:0]    asid
);
  logic [VA_W-1:0] regs_q [N_CAP];
  logic [VA_W-1:0] regs_d [N_CAP];
  logic [N_CAP-1:0] upd;

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    logic [VA_W-1:0] keep_mask;
    logic [VA_W-1:0] slice_val;
    if (i == 0) begin : g_badva
      assign keep_mask = '0;
      assign slice_val = cap_vaddr;
    end else if (i == 1) begin : g_ctx
      assign keep_mask = CTX_KEEP;
      assign slice_val = (cap_vaddr >> 9) & CTX_SLICE;
    end else begin : g_ehi
      assign keep_mask = EHI_KEEP;
      assign slice_val = cap_vaddr & EHI_SLICE;
    end

    always_comb begin
      upd[i]    = cap_en || (wr_en && (wr_sel == CAP_SEL_W'(i)));
      regs_d[i] = regs_q[i];
      if (cap_en)
        regs_d[i] = (regs_q[i] & keep_mask) | (slice_val & ~keep_mask);
      else if (wr_en && (wr_sel == CAP_SEL_W'(i)))
        regs_d[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[i] <= '0;
      else if (upd[i]) regs_q[i] <= regs_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N_CAP; k++)
      if (rd_sel == CAP_SEL_W'(k)) rd_data = regs_q[k];
  end

  assign asid = regs_q[2][ASID_W-1:0];

  AST_BADVA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> regs_q[0] == $past(cap_vaddr)); // R9
  AST_CTX_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> regs_q[1][31:23] == $past(regs_q[1][31:23])); // R10
  AST_EHI_KEEP_ASID: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> regs_q[2][7:0] == $past(regs_q[2][7:0])); // R11
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_en) |=> ($stable(regs_q[0]) && $stable(regs_q[1]) && $stable(regs_q[2]))); // R12
endmodule

// File: rtl/xlate_mmu_front.sv
module xlate_mmu_front
  import xlate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic                 req_write,
  input  logic                 req_user,
  input  logic                 req_errlvl,
  output logic                 tlb_req,
  output logic [ASID_W-1:0]    tlb_asid,
  input  logic                 tlb_hit,
  input  logic                 tlb_valid,
  input  logic                 tlb_dirty,
  input  logic [VA_W-1:0]      tlb_paddr,
  output logic                 rsp_valid,
  output logic [VA_W-1:0]      rsp_paddr,
  output logic                 rsp_rd_ok,
  output logic                 rsp_wr_ok,
  output logic                 rsp_fault,
  output logic [4:0]           rsp_exc,
  output logic                 rsp_refill,
  input  logic                 reg_wr_en,
  input  logic [CAP_SEL_W-1:0] reg_wr_sel,
  input  logic [VA_W-1:0]      reg_wr_data,
  input  logic [CAP_SEL_W-1:0] reg_rd_sel,
  output logic [VA_W-1:0]      reg_rd_data
);
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seg_kind_e       kind;
  logic [VA_W-1:0] direct_paddr;
  xlate_rsp_t      rsp_d, rsp_q;
  logic            vld_d, vld_q;

  xlate_seg_decode u_dec (
    .vaddr(req_vaddr), .user(req_user), .errlvl(req_errlvl),
    .kind(kind), .direct_paddr(direct_paddr));

  xlate_fault_classify u_cls (
    .kind(kind), .direct_paddr(direct_paddr), .write(req_write),
    .tlb_hit(tlb_hit), .tlb_valid(tlb_valid), .tlb_dirty(tlb_dirty),
    .tlb_paddr(tlb_paddr), .rsp(rsp_d));

  assign tlb_req = req_valid && (kind == SEG_TLB);
  assign vld_d   = req_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (req_valid) rsp_q <= rsp_d;
    end
  end

  xlate_capture_regs u_cap (
    .clk(clk), .rst_n(rst_sync_n),
    .cap_en(req_valid && rsp_d.fault), .cap_vaddr(req_vaddr),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .rd_sel(reg_rd_sel), .rd_data(reg_rd_data), .asid(tlb_asid));

  assign rsp_valid  = vld_q;
  assign rsp_paddr  = rsp_q.paddr;
  assign rsp_rd_ok  = rsp_q.rd_ok;
  assign rsp_wr_ok  = rsp_q.wr_ok;
  assign rsp_fault  = rsp_q.fault;
  assign rsp_exc    = rsp_q.exc;
  assign rsp_refill = rsp_q.refill;

  AST_USER_HIGH_FAULTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_user && req_vaddr[31]) |=> (rsp_fault && !rsp_refill &&
      (rsp_exc == 5'd4 || rsp_exc == 5'd5))); // R1
  AST_REFILL_IS_TLB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_refill |-> (rsp_fault && (rsp_exc == 5'd2 || rsp_exc == 5'd3))); // R8
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_fault |-> (!rsp_rd_ok && !rsp_wr_ok && rsp_paddr == '0)); // R9
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid); // R13
endmodule

// File: tb/xlate_mmu_front_tb_top.sv
module xlate_mmu_front_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_user, req_errlvl;
  logic [31:0] req_vaddr;
  logic        tlb_req;
  logic [7:0]  tlb_asid;
  logic        tlb_hit, tlb_valid, tlb_dirty;
  logic [31:0] tlb_paddr;
  logic        rsp_valid, rsp_rd_ok, rsp_wr_ok, rsp_fault, rsp_refill;
  logic [31:0] rsp_paddr;
  logic [4:0]  rsp_exc;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_sel, reg_rd_sel;
  logic [31:0] reg_wr_data, reg_rd_data;

  int checks = 0;
  int fails  = 0;
  logic tlb_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_mmu_front dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .req_errlvl(req_errlvl),
    .tlb_req(tlb_req), .tlb_asid(tlb_asid), .tlb_hit(tlb_hit),
    .tlb_valid(tlb_valid), .tlb_dirty(tlb_dirty), .tlb_paddr(tlb_paddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_rd_ok(rsp_rd_ok),
    .rsp_wr_ok(rsp_wr_ok), .rsp_fault(rsp_fault), .rsp_exc(rsp_exc),
    .rsp_refill(rsp_refill), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] va, input logic w, input logic u, input logic e,
                       input logic hit, input logic vld, input logic drt, input logic [31:0] tpa);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u; req_errlvl = e;
    tlb_hit = hit; tlb_valid = vld; tlb_dirty = drt; tlb_paddr = tpa;
    #1 tlb_seen = tlb_req;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic treq, input logic flt,
                            input logic [4:0] exc, input logic rf, input logic [31:0] pa,
                            input logic rd, input logic wr);
    chk({tag, " tlb_req"}, 32'(tlb_seen), 32'(treq));
    chk({tag, " valid"},   32'(rsp_valid), 32'd1);
    chk({tag, " fault"},   32'(rsp_fault), 32'(flt));
    chk({tag, " exc"},     32'(rsp_exc), 32'(exc));
    chk({tag, " refill"},  32'(rsp_refill), 32'(rf));
    chk({tag, " paddr"},   rsp_paddr, pa);
    chk({tag, " rd"},      32'(rsp_rd_ok), 32'(rd));
    chk({tag, " wr"},      32'(rsp_wr_ok), 32'(wr));
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_check(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    reg_rd_sel = sel;
    #1 chk(tag, reg_rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R13 reset rsp_valid", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < 3; i++) reg_check("R13 reset capture", 2'(i), 32'd0);
  endtask

  task automatic t_direct;
    issue(32'h8123_4560, 0, 0, 0, 0, 0, 0, 32'h0);
    expect_rsp("R4 win4", 0, 0, 0, 0, 32'h0123_4560, 1, 1);
    issue(32'h9FFF_FFFC, 1, 0, 0, 0, 0, 0, 32'h0);
    expect_rsp("R4 win4 top", 0, 0, 0, 0, 32'h1FFF_FFFC, 1, 1);
    issue(32'hA000_1000, 1, 0, 0, 0, 0, 0, 32'h0);
    expect_rsp("R5 win5", 0, 0, 0, 0, 32'h0000_1000, 1, 1);
    issue(32'h1234_5678, 1, 0, 1, 0, 0, 0, 32'h0);
    expect_rsp("R3 errlvl", 0, 0, 0, 0, 32'h1234_5678, 1, 1);
    issue(32'h7FFF_FFFF, 0, 1, 1, 0, 0, 0, 32'h0);
    expect_rsp("R3 user low errlvl", 0, 0, 0, 0, 32'h7FFF_FFFF, 1, 1);
  endtask

  task automatic t_tlb_ok;
    issue(32'h0040_0000, 1, 0, 0, 1, 1, 1, 32'h0ABC_D000);
    expect_rsp("R2 R7 hit dirty", 1, 0, 0, 0, 32'h0ABC_D000, 1, 1);
    issue(32'h0040_0000, 0, 1, 0, 1, 1, 0, 32'h0000_2000);
    expect_rsp("R2 R7 hit clean read", 1, 0, 0, 0, 32'h0000_2000, 1, 0);
    issue(32'hC000_0000, 0, 0, 1, 1, 1, 1, 32'h0000_3000);
    expect_rsp("R6 win6", 1, 0, 0, 0, 32'h0000_3000, 1, 1);
    issue(32'hE000_0040, 0, 0, 0, 1, 1, 0, 32'h0000_4040);
    expect_rsp("R6 win7", 1, 0, 0, 0, 32'h0000_4040, 1, 0);
  endtask

  task automatic t_faults;
    issue(32'h8000_0000, 0, 1, 0, 1, 1, 1, 32'h0);
    expect_rsp("R1 user read", 0, 1, 5'd4, 0, 32'h0, 0, 0);
    issue(32'hC000_1000, 1, 1, 1, 1, 1, 1, 32'h0);
    expect_rsp("R1 user write", 0, 1, 5'd5, 0, 32'h0, 0, 0);
    issue(32'h0000_5000, 0, 0, 0, 0, 0, 0, 32'h0);
    expect_rsp("R8 miss load", 1, 1, 5'd2, 1, 32'h0, 0, 0);
    issue(32'hD000_5000, 1, 0, 0, 0, 1, 1, 32'h0);
    expect_rsp("R8 miss store", 1, 1, 5'd3, 1, 32'h0, 0, 0);
    issue(32'h0000_6000, 0, 0, 0, 1, 0, 1, 32'h0);
    expect_rsp("R8 invalid load", 1, 1, 5'd2, 0, 32'h0, 0, 0);
    issue(32'h0000_6000, 1, 0, 0, 1, 0, 1, 32'h0);
    expect_rsp("R8 invalid store", 1, 1, 5'd3, 0, 32'h0, 0, 0);
    issue(32'h0000_7000, 1, 0, 0, 1, 1, 0, 32'h0);
    expect_rsp("R7 modified", 1, 1, 5'd1, 0, 32'h0, 0, 0);
  endtask

  task automatic t_capture;
    logic [31:0] va;
    va = 32'h1234_5678;
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_write(2'd2, 32'hFFFF_FFFF);
    reg_check("R12 write ctx", 2'd1, 32'hFFFF_FFFF);
    chk("R11 asid out", 32'(tlb_asid), 32'hFF);
    issue(va, 0, 0, 0, 0, 0, 0, 32'h0);
    reg_check("R9 badva", 2'd0, va);
    reg_check("R10 context", 2'd1, 32'hFF80_0000 | ((va >> 9) & 32'h007F_FFF0));
    reg_check("R11 entryhi", 2'd2, 32'h0000_00FF | (va & 32'hFFFF_E000));
    reg_check("R12 sel3 zero", 2'd3, 32'h0);
    issue(32'h8765_4321, 1, 0, 0, 0, 0, 0, 32'h0);
    reg_check("R12 no-fault hold badva", 2'd0, va);
    reg_check("R12 no-fault hold ctx", 2'd1, 32'hFF80_0000 | ((va >> 9) & 32'h007F_FFF0));
    reg_write(2'd2, 32'h0000_0012);
    va = 32'hFEDC_BA98;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = 1'b1; req_user = 1'b1; req_errlvl = 1'b0;
    reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 32'h5555_5555;
    @(negedge clk);
    req_valid = 1'b0; reg_wr_en = 1'b0;
    chk("R1 exc with write", 32'(rsp_exc), 32'd5);
    reg_check("R12 fault beats write", 2'd2, 32'h0000_0012 | (va & 32'hFFFF_E000));
    reg_check("R9 badva second", 2'd0, va);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
    req_errlvl = 1'b0; tlb_hit = 1'b0; tlb_valid = 1'b0; tlb_dirty = 1'b0; tlb_paddr = '0;
    reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0; reg_rd_sel = '0; tlb_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direct();
    t_tlb_ok();
    t_faults();
    t_capture();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule